// File: doc/BRIEF.md
# Periodic Divider with Watchdog Reset

This block runs a free-running binary prescaler off the system clock. Each time the prescaler wraps around, it sets a sticky event flag. The flag is gated by two enable inputs to form an interrupt request and a hold-release request. Software clears the flag with a strobe. A second strobe zeroes only the top stages of the prescaler, which lets software re-phase the next period without disturbing the fine stages.

The same prescaler also drives a small watchdog counter. One of two prescaler taps is chosen by a select input. The watchdog does not use that tap as a clock: it detects the tap's rising edge synchronously and counts one step on each rising edge. When the watchdog carries out, a controller issues a one-cycle system reset pulse, but only if the build-time enable parameter is set. The pulse also returns the prescaler and the watchdog to zero. Software keeps the pulse from firing by clearing the watchdog, either with its own strobe or with the clear-prescaler strobe.

The reset controller is a two-state machine:
- `ST_RUN` is the resting state.
- The transition *carry-fire* leaves `ST_RUN` for `ST_FIRE` when the watchdog carries and the watchdog is enabled.
- `ST_FIRE` drives the reset output for exactly one cycle.
- The unconditional transition *fire-done* leads from `ST_FIRE` back to `ST_RUN`.
- Without a carry, the transition *stay* keeps the machine in `ST_RUN`.

Top module: `prdw_top`

## Requirements
- R1: The prescaler is a 14-bit up-counter. It is zero after reset, advances by one on every clock and wraps from 16383 to 0.
- R2: A wrap sets the event flag, so the flag first reads 1 after the 16384th clock after reset. A clear-flag strobe drops the flag on the following edge. A wrap on the same edge as a clear-flag strobe leaves the flag set.
- R3: The interrupt request equals the event flag AND the interrupt enable. The hold-release request equals the event flag AND the hold enable. Both follow their inputs without a register.
- R4: The clear-prescaler strobe zeroes prescaler bits 13..10, while bits 9..0 keep counting. It also zeroes the watchdog.
- R5: The watchdog is a 4-bit counter that steps on each rising edge of the selected tap:
  - with select 0, the tap is prescaler bit 10 (period 2048 clocks);
  - with select 1, the tap is prescaler bit 13 (period 16384 clocks).
  - The step taken from 15 is the carry. From reset with select 0 and no clears, the reset pulse is high after the 31745th clock.
- R6: The clear-watchdog strobe zeroes the watchdog on the next edge.
- R7: The system reset output is a pulse exactly one cycle wide. On the edge that ends it, the prescaler and the watchdog return to zero.
- R8: With the build-time watchdog enable at 0, the system reset output never rises.
- R9: During and right after reset, the event flag, both requests and the system reset output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_div_i | input | 1 | Strobe: zero the upper prescaler stages and the watchdog |
| clr_wdt_i | input | 1 | Strobe: zero the watchdog |
| clr_evt_i | input | 1 | Strobe: clear the event flag |
| int_en_i | input | 1 | Interrupt enable |
| hold_en_i | input | 1 | Hold-release enable |
| tap_sel_i | input | 1 | Watchdog tap select (0: divide by 2048, 1: divide by 16384) |
| evt_flag_o | output | 1 | Sticky prescaler wrap flag |
| int_req_o | output | 1 | Interrupt request |
| hold_req_o | output | 1 | Hold-release request |
| sys_rst_o | output | 1 | One-cycle system reset pulse |

## Verification
On every cycle, the assertions check the following local rules:
- the prescaler's plus-one step, and the partial clear that keeps the low stages moving;
- the flag's set, hold and clear rules, including set winning over clear;
- the watchdog standing still between tap edges and zeroing on a clear;
- the reset pulse being one cycle wide and caused by a carry.

Only the bench's long scenarios can show the absolute timing. That covers the cycle on which the first wrap and the watchdog pulse appear, the shift of both after a clear-prescaler strobe or a clear-watchdog strobe, the absence of a pulse with the slow tap or with the watchdog disabled, and the wrap timing restarting after a pulse.

// File: rtl/prdw_pkg.sv
package prdw_pkg;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_FIRE = 1'b1
    } prdw_state_e;

endpackage

// File: rtl/prdw_divider.sv
module prdw_divider #(
    parameter int W        = 14,
    parameter int CLR_BITS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_hi_i,
    input  logic         pulse_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    localparam int LO_W = W - CLR_BITS;

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_inc;

    assign cnt_inc = cnt_q + W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (pulse_i) begin
            cnt_q <= '0;
        end else if (clr_hi_i) begin
            cnt_q <= {{CLR_BITS{1'b0}}, cnt_inc[LO_W-1:0]};
        end else begin
            cnt_q <= cnt_inc;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = (&cnt_q) && !clr_hi_i && !pulse_i;

    // R1: plain step when nothing clears the prescaler
    assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_i && !clr_hi_i) |=> (cnt_q == $past(cnt_q) + W'(1)));

    // R4: upper stages zeroed, lower stages keep counting
    assert_upper_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hi_i && !pulse_i) |=> ((cnt_q[W-1:LO_W] == '0) &&
            (cnt_q[LO_W-1:0] == $past(cnt_q[LO_W-1:0]) + LO_W'(1))));

    // R7: the reset pulse empties the prescaler
    assert_pulse_clears_div_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_i |=> (cnt_q == '0));
endmodule

// File: rtl/prdw_watchdog.sv
module prdw_watchdog #(
    parameter int W = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tap_lo_i,
    input  logic tap_hi_i,
    input  logic sel_i,
    input  logic clr_i,
    output logic carry_o
);
    logic [W-1:0] wdt_q;
    logic         tap;
    logic         tap_q;
    logic         rise;

    assign tap  = sel_i ? tap_hi_i : tap_lo_i;
    assign rise = tap && !tap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= 1'b0;
        end else begin
            tap_q <= tap;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wdt_q <= '0;
        end else if (clr_i) begin
            wdt_q <= '0;
        end else if (rise) begin
            wdt_q <= wdt_q + W'(1);
        end
    end

    assign carry_o = rise && (&wdt_q) && !clr_i;

    // R6: any clear empties the watchdog on the next edge
    assert_wdt_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (wdt_q == '0));

    // R5: the watchdog only moves on a tap rising edge
    assert_wdt_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !rise) |=> $stable(wdt_q));

    // R5: a tap edge without a clear advances the count by one
    assert_wdt_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && rise) |=> (wdt_q == $past(wdt_q) + W'(1)));
endmodule

// File: rtl/prdw_event.sv
module prdw_event (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic int_en_i,
    input  logic hold_en_i,
    output logic flag_o,
    output logic int_o,
    output logic hold_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign int_o  = flag_q & int_en_i;
    assign hold_o = flag_q & hold_en_i;

    // R2: the flag only rises after a prescaler wrap
    assert_evt_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_i));

    // R2: set wins over a simultaneous clear
    assert_evt_set_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R2: a clear without a wrap drops the flag
    assert_evt_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
endmodule

// File: rtl/prdw_reset_fsm.sv
module prdw_reset_fsm
    import prdw_pkg::*;
#(
    parameter bit WDT_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic carry_i,
    output logic pulse_o
);
    prdw_state_e state_q;
    prdw_state_e state_d;
    logic        fire;

    generate
        if (WDT_EN) begin : g_wdt_on
            assign fire = carry_i;
        end else begin : g_wdt_off
            assign fire = 1'b0;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = fire ? ST_FIRE : ST_RUN;
            ST_FIRE: state_d = ST_RUN;
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        pulse_o = 1'b0;
        unique case (state_q)
            ST_RUN:  pulse_o = 1'b0;
            ST_FIRE: pulse_o = 1'b1;
            default: pulse_o = 1'b0;
        endcase
    end

    // R7: the reset pulse is a single cycle wide
    assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

    // R5: a pulse starts only after a watchdog carry
    assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> $past(carry_i));

    // R8: a disabled watchdog never starts a pulse
    assert_pulse_enabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_o) |-> WDT_EN);
endmodule

// File: rtl/prdw_top.sv
module prdw_top #(
    parameter int DIV_W      = 14,
    parameter int CLR_BITS   = 4,
    parameter int WDT_W      = 4,
    parameter int TAP_LO_DIV = 2048,
    parameter int TAP_HI_DIV = 16384,
    parameter bit WDT_EN     = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_div_i,
    input  logic clr_wdt_i,
    input  logic clr_evt_i,
    input  logic int_en_i,
    input  logic hold_en_i,
    input  logic tap_sel_i,
    output logic evt_flag_o,
    output logic int_req_o,
    output logic hold_req_o,
    output logic sys_rst_o
);
    localparam int TAP_LO_IDX = $clog2(TAP_LO_DIV) - 1;
    localparam int TAP_HI_IDX = $clog2(TAP_HI_DIV) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic             div_wrap;
    logic             wdt_carry;
    logic             wdt_clr;
    logic             rst_pulse;

    assign wdt_clr = clr_wdt_i | clr_div_i | rst_pulse;

    prdw_divider #(
        .W        (DIV_W),
        .CLR_BITS (CLR_BITS)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_hi_i (clr_div_i),
        .pulse_i  (rst_pulse),
        .cnt_o    (div_cnt),
        .wrap_o   (div_wrap)
    );

    prdw_watchdog #(
        .W (WDT_W)
    ) u_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tap_lo_i (div_cnt[TAP_LO_IDX]),
        .tap_hi_i (div_cnt[TAP_HI_IDX]),
        .sel_i    (tap_sel_i),
        .clr_i    (wdt_clr),
        .carry_o  (wdt_carry)
    );

    prdw_event u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (div_wrap),
        .clr_i     (clr_evt_i),
        .int_en_i  (int_en_i),
        .hold_en_i (hold_en_i),
        .flag_o    (evt_flag_o),
        .int_o     (int_req_o),
        .hold_o    (hold_req_o)
    );

    prdw_reset_fsm #(
        .WDT_EN (WDT_EN)
    ) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .carry_i (wdt_carry),
        .pulse_o (rst_pulse)
    );

    assign sys_rst_o = rst_pulse;
endmodule

// File: tb/test_prdw_top.sv
`timescale 1ns/1ps
module test_prdw_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n;
    logic clr_div, clr_wdt, clr_evt, int_en, hold_en, tap_sel;
    logic evt, irq, hreq, srst;
    logic evt_n, irq_n, hreq_n, srst_n;

    prdw_top i_prdw_top (
        .clk(clk), .rst_n(rst_n), .clr_div_i(clr_div), .clr_wdt_i(clr_wdt),
        .clr_evt_i(clr_evt), .int_en_i(int_en), .hold_en_i(hold_en),
        .tap_sel_i(tap_sel), .evt_flag_o(evt), .int_req_o(irq),
        .hold_req_o(hreq), .sys_rst_o(srst)
    );

    prdw_top #(.WDT_EN(1'b0)) i_nowdt (
        .clk(clk), .rst_n(rst_n), .clr_div_i(clr_div), .clr_wdt_i(clr_wdt),
        .clr_evt_i(clr_evt), .int_en_i(int_en), .hold_en_i(hold_en),
        .tap_sel_i(tap_sel), .evt_flag_o(evt_n), .int_req_o(irq_n),
        .hold_req_o(hreq_n), .sys_rst_o(srst_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc;
    int rst_seen;
    int rst_seen_off = 0;

    typedef struct {
        int    cyc;
        int    sig;
        logic  val;
        string req;
    } exp_t;
    exp_t q[$];
    exp_t mon_e;

    localparam int S_EVT = 0, S_INT = 1, S_HOLD = 2, S_RST = 3;

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: %s actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    task automatic check_int(input int act, input int exp, input string req, input string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(input int c, input int s, input logic v, input string r);
        exp_t e;
        e.cyc = c; e.sig = s; e.val = v; e.req = r;
        q.push_back(e);
    endtask

    function automatic logic pick(input int s);
        case (s)
            S_EVT:   return evt;
            S_INT:   return irq;
            S_HOLD:  return hreq;
            default: return srst;
        endcase
    endfunction

    // monitor: compares scoreboard entries in the cycle they name
    always @(negedge clk) begin
        if (rst_n) begin
            if (srst)   rst_seen++;
            if (srst_n) rst_seen_off++;
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                mon_e = q.pop_front();
                if (mon_e.cyc < cyc)
                    check(1'bx, mon_e.val, mon_e.req, $sformatf("missed sample cycle %0d", mon_e.cyc));
                else
                    check(pick(mon_e.sig), mon_e.val, mon_e.req,
                          $sformatf("signal %0d at cycle %0d", mon_e.sig, mon_e.cyc));
            end
        end
    end

    task automatic wait_cyc(input int n);
        @(negedge clk);
        while (cyc != n) @(negedge clk);
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic apply_reset(input logic sel);
        rst_n = 1'b0;
        tap_sel = sel;
        clr_div = 1'b0; clr_wdt = 1'b0; clr_evt = 1'b0;
        repeat (3) @(negedge clk);
        rst_seen = 0;
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0;
        int_en = 1'b0; hold_en = 1'b0;
        clr_div = 1'b0; clr_wdt = 1'b0; clr_evt = 1'b0; tap_sel = 1'b0;
        rst_seen = 0;

        // scenario A: first wrap, gating, flag clear, watchdog pulse
        int_en = 1'b1;
        apply_reset(1'b0);
        check(evt, 1'b0, "R9", "flag after reset");
        check(srst, 1'b0, "R9", "reset out after reset");
        push(1, S_EVT, 1'b0, "R9");
        push(1, S_INT, 1'b0, "R9");
        push(1, S_HOLD, 1'b0, "R9");
        push(1, S_RST, 1'b0, "R9");
        push(16383, S_EVT, 1'b0, "R1,R2");
        push(16384, S_EVT, 1'b1, "R1,R2 set wins");
        push(16384, S_INT, 1'b1, "R3");
        push(16384, S_HOLD, 1'b0, "R3");
        push(16388, S_HOLD, 1'b1, "R3");
        push(16391, S_EVT, 1'b0, "R2");
        push(16391, S_INT, 1'b0, "R3");
        push(31744, S_RST, 1'b0, "R5");
        push(31745, S_RST, 1'b1, "R5");
        push(31746, S_RST, 1'b0, "R7");
        push(48129, S_EVT, 1'b0, "R7");
        push(48130, S_EVT, 1'b1, "R7");
        wait_cyc(16383); clr_evt = 1'b1; @(negedge clk); clr_evt = 1'b0;
        wait_cyc(16386); hold_en = 1'b1;
        wait_cyc(16390); clr_evt = 1'b1; @(negedge clk); clr_evt = 1'b0;
        drain();
        check_int(rst_seen, 1, "R7", "pulses in scenario A");
        hold_en = 1'b0;

        // scenario B: clear-watchdog strobe postpones the pulse
        apply_reset(1'b0);
        push(31745, S_RST, 1'b0, "R6");
        push(52224, S_RST, 1'b0, "R6");
        push(52225, S_RST, 1'b1, "R6");
        wait_cyc(20000); clr_wdt = 1'b1; @(negedge clk); clr_wdt = 1'b0;
        drain();
        check_int(rst_seen, 1, "R6", "pulses in scenario B");

        // scenario C: clear-prescaler strobe clears upper stages and watchdog
        apply_reset(1'b0);
        push(16384, S_EVT, 1'b0, "R4");
        push(25599, S_EVT, 1'b0, "R4");
        push(25600, S_EVT, 1'b1, "R4");
        push(31745, S_RST, 1'b0, "R4");
        push(40960, S_RST, 1'b0, "R4");
        push(40961, S_RST, 1'b1, "R4");
        wait_cyc(10000); clr_div = 1'b1; @(negedge clk); clr_div = 1'b0;
        drain();
        check_int(rst_seen, 1, "R4", "pulses in scenario C");

        // scenario D: slow tap, no pulse where the fast tap would fire
        apply_reset(1'b1);
        push(31745, S_RST, 1'b0, "R5");
        push(33000, S_RST, 1'b0, "R5");
        drain();
        check_int(rst_seen, 0, "R5", "pulses with slow tap");

        check_int(rst_seen_off, 0, "R8", "pulses with watchdog disabled");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run incomplete actual %0d cycles expected fewer", 195000);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule